// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer Counter

This block is an 8-bit counter that advances only on cycles where a tick enable is high. A prescaler outside the block drives that enable. A two-bit mode input picks one of four counting rules. The rules are free-running wrap, restart at a programmable limit, a one-shot count down that stops at zero, and a triangle that climbs to the limit and falls back to zero. The limit is a terminal count value presented on an input port. Every rule has its own point at which the counter reloads or holds, and its own point at which an overflow event occurs.

An overflow event sets a sticky flag. Software clears the flag with a one-cycle strobe. Two outputs come from the flag. The first is a status output, qualified by an overflow mask bit. The second is an interrupt request, which also needs a separate interrupt enable. A run input starts and stops the timer. When run rises in the down mode, the counter is loaded with the terminal count.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset the count is 0x00, the sticky overflow flag is clear, stat_flag and irq are low, and the up/down direction is up.
- R2: The count changes only on a clock edge where tick_en and run are both high. The one exception is the down-mode start load of R5. With run low, or with tick_en low, the count holds.
- R3: With mode = 2'b00 (free-running), each tick adds one. A tick at 0xFF wraps the count to 0x00 and raises the overflow flag.
- R4: With mode = 2'b01 (modulo), each tick adds one until the count equals term_cnt. The next tick then reloads 0x00. The overflow flag is raised on the tick that brings the count to term_cnt.
- R5: With mode = 2'b10 (down), the clock edge on which run goes from low to high loads term_cnt into the count, whatever tick_en is. Each later tick subtracts one. Once the count is 0x00 it holds there. The flag is raised only on the tick that brings the count to 0x00.
- R6: With mode = 2'b11 (up/down), the count climbs from 0x00 to term_cnt, then falls to 0x00, then climbs again, without end. The flag is raised on each tick that brings the count to 0x00.
- R7: With term_cnt = 0x00 in modulo or up/down mode, the count stays at 0x00 and every tick raises the flag.
- R8: The overflow flag is sticky. A one-cycle flag_clr clears it. An overflow event in the same cycle as flag_clr wins, and the flag stays set.
- R9: stat_flag is high only while the sticky flag is set and ovf_mask is 1.
- R10: irq is high only while the sticky flag is set, ovf_mask is 1, and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advance enable from a prescaler |
| run | input | 1 | Timer run control; a rising level starts the timer |
| mode | input | 2 | Counting rule: 00 free, 01 modulo, 10 down, 11 up/down |
| term_cnt | input | 8 | Terminal count value |
| flag_clr | input | 1 | One-cycle strobe that clears the sticky flag |
| ovf_mask | input | 1 | Overflow mask bit |
| irq_en | input | 1 | Timer interrupt enable |
| count | output | 8 | Present counter value |
| stat_flag | output | 1 | Masked overflow status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle: the count holds when no tick is allowed, the free-running wrap to zero, the down-mode hold at zero, and that the flag is set after any overflow event. They also check that a clear without a competing event empties the flag, and that the mask and enable qualify both outputs. Some behaviours show only as sequences over many ticks, so only the directed scenarios can show them. These are the exact up/down triangle, the modulo reload point, the down-mode start load, the term_cnt = 0 corner, and the step-by-step values where each mode raises its flag.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_MOD  = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;

endpackage

// File: rtl/tmr8_step.sv
module tmr8_step
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  tmr_mode_e      mode_i,
  input  logic [W-1:0]   cnt_i,
  input  logic [W-1:0]   tc_i,
  input  logic           dir_up_i,
  input  logic           load_i,
  input  logic           adv_i,
  output logic [W-1:0]   cnt_o,
  output logic           dir_up_o,
  output logic           ev_o
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  function automatic logic [W-1:0] f_inc(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [W-1:0] f_dec(input logic [W-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic f_zero(input logic [W-1:0] v);
    return v == ZERO;
  endfunction

  always_comb begin
    cnt_o    = cnt_i;
    dir_up_o = dir_up_i;
    ev_o     = 1'b0;
    if (load_i) begin
      cnt_o    = tc_i;
      dir_up_o = 1'b1;
    end else if (adv_i) begin
      unique case (mode_i)
        MODE_FREE: begin
          cnt_o = f_inc(cnt_i);
          ev_o  = (cnt_i == TOP);
        end
        MODE_MOD: begin
          cnt_o = (cnt_i >= tc_i) ? ZERO : f_inc(cnt_i);
          ev_o  = (cnt_o == tc_i);
        end
        MODE_DOWN: begin
          if (!f_zero(cnt_i)) begin
            cnt_o = f_dec(cnt_i);
            ev_o  = f_zero(cnt_o);
          end
        end
        MODE_UPDN: begin
          if (dir_up_i && (cnt_i < tc_i)) begin
            cnt_o = f_inc(cnt_i);
          end else if (f_zero(cnt_i)) begin
            cnt_o    = ZERO;
            dir_up_o = 1'b1;
            ev_o     = 1'b1;
          end else begin
            cnt_o    = f_dec(cnt_i);
            dir_up_o = f_zero(cnt_o);
            ev_o     = f_zero(cnt_o);
          end
        end
        default: cnt_o = cnt_i;
      endcase
    end
  end

endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic clr_i,
  input  logic mask_i,
  input  logic ien_i,
  output logic flag_o,
  output logic stat_o,
  output logic irq_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= ev_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign stat_o = flag_q & mask_i;
  assign irq_o  = flag_q & mask_i & ien_i;

endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         run,
  input  logic [1:0]   mode,
  input  logic [W-1:0] term_cnt,
  input  logic         flag_clr,
  input  logic         ovf_mask,
  input  logic         irq_en,
  output logic [W-1:0] count,
  output logic         stat_flag,
  output logic         irq
);

  tmr_mode_e    mode_e;
  logic         run_q;
  logic         start_pulse;
  logic         load_now;
  logic         adv;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         up_q;
  logic         up_nxt;
  logic         ev_ovf;
  logic         ovf_sticky;

  assign mode_e      = tmr_mode_e'(mode);
  assign start_pulse = run & ~run_q;
  assign load_now    = start_pulse & (mode_e == MODE_DOWN);
  assign adv         = tick_en & run & ~load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      run_q <= run;
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
    end
  end

  tmr8_step #(.W(W)) u_step (
    .mode_i   (mode_e),
    .cnt_i    (cnt_q),
    .tc_i     (term_cnt),
    .dir_up_i (up_q),
    .load_i   (load_now),
    .adv_i    (adv),
    .cnt_o    (cnt_nxt),
    .dir_up_o (up_nxt),
    .ev_o     (ev_ovf)
  );

  tmr8_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (ev_ovf),
    .clr_i  (flag_clr),
    .mask_i (ovf_mask),
    .ien_i  (irq_en),
    .flag_o (ovf_sticky),
    .stat_o (stat_flag),
    .irq_o  (irq)
  );

  assign count = cnt_q;

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         run,
  input logic [1:0]   mode,
  input logic         start_pulse,
  input logic         ev_ovf,
  input logic         ovf_sticky,
  input logic         flag_clr,
  input logic         ovf_mask,
  input logic         irq_en,
  input logic [W-1:0] count,
  input logic         stat_flag,
  input logic         irq
);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !start_pulse) |=> $stable(count));

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R3
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && tick_en && run && !start_pulse && count == {W{1'b1}})
      |=> (count == '0 && ovf_sticky));

  // R5
  down_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && count == '0 && !start_pulse) |=> count == '0);

  // R8
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> ovf_sticky);

  // R8
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ev_ovf) |=> !ovf_sticky);

  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_mask || !ovf_sticky) |-> !stat_flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_flag && irq_en));

endmodule

bind tmr8_multimode tmr8_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .run         (run),
  .mode        (mode),
  .start_pulse (start_pulse),
  .ev_ovf      (ev_ovf),
  .ovf_sticky  (ovf_sticky),
  .flag_clr    (flag_clr),
  .ovf_mask    (ovf_mask),
  .irq_en      (irq_en),
  .count       (count),
  .stat_flag   (stat_flag),
  .irq         (irq)
);

// File: tb/tmr8_multimode_test.sv
`timescale 1ns/1ps
module tmr8_multimode_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       run = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] term_cnt = 8'h00;
  logic       flag_clr = 1'b0;
  logic       ovf_mask = 1'b1;
  logic       irq_en = 1'b0;
  logic [7:0] count;
  logic       stat_flag;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr8_multimode uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .mode(mode),
    .term_cnt(term_cnt), .flag_clr(flag_clr), .ovf_mask(ovf_mask),
    .irq_en(irq_en), .count(count), .stat_flag(stat_flag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    idle(1);
    flag_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 0; run = 0; mode = 0; term_cnt = 0;
    flag_clr = 0; ovf_mask = 1; irq_en = 0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 stat_flag", stat_flag, 0);
    irq_en = 1; #1;
    chk("R1 irq", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_hold();
    do_reset();
    ticks(3);
    chk("R2 run low hold", count, 0);
    run = 1; idle(1);
    idle(4);
    chk("R2 tick low hold", count, 0);
    ticks(2);
    chk("R2 advance", count, 2);
    run = 0;
    ticks(3);
    chk("R2 stopped hold", count, 2);
  endtask

  task automatic t_free();
    do_reset();
    run = 1; idle(1);
    ticks(255);
    chk("R3 at top", count, 255);
    chk("R3 no flag yet", stat_flag, 0);
    ticks(1);
    chk("R3 wrap", count, 0);
    chk("R3 flag on wrap", stat_flag, 1);
  endtask

  task automatic t_mod();
    do_reset();
    mode = 2'b01; term_cnt = 8'd5;
    run = 1; idle(1);
    ticks(4);
    chk("R4 count 4", count, 4);
    chk("R4 no flag", stat_flag, 0);
    ticks(1);
    chk("R4 reach tc", count, 5);
    chk("R4 flag", stat_flag, 1);
    clear_flag();
    ticks(1);
    chk("R4 reload", count, 0);
    chk("R4 no flag reload", stat_flag, 0);
    ticks(5);
    chk("R4 second flag", stat_flag, 1);
  endtask

  task automatic t_down();
    do_reset();
    mode = 2'b10; term_cnt = 8'd4;
    run = 1; idle(1);
    chk("R5 load", count, 4);
    ticks(3);
    chk("R5 count 1", count, 1);
    chk("R5 no flag", stat_flag, 0);
    ticks(1);
    chk("R5 zero", count, 0);
    chk("R5 flag", stat_flag, 1);
    clear_flag();
    ticks(3);
    chk("R5 stays zero", count, 0);
    chk("R5 no reflag", stat_flag, 0);
  endtask

  task automatic t_updn();
    int exp_seq[8] = '{1, 2, 3, 2, 1, 0, 1, 2};
    do_reset();
    mode = 2'b11; term_cnt = 8'd3;
    run = 1; idle(1);
    for (int i = 0; i < 8; i++) begin
      ticks(1);
      chk("R6 sequence", count, exp_seq[i]);
      chk("R6 flag", stat_flag, (i >= 5) ? 1 : 0);
    end
  endtask

  task automatic t_zero();
    do_reset();
    mode = 2'b01; term_cnt = 8'd0;
    run = 1; idle(1);
    ticks(1);
    chk("R7 modulo zero", count, 0);
    chk("R7 modulo flag", stat_flag, 1);
    flag_clr = 1; ticks(1); flag_clr = 0;
    chk("R8 event beats clear", stat_flag, 1);
    clear_flag();
    chk("R8 cleared", stat_flag, 0);
    mode = 2'b11;
    ticks(2);
    chk("R7 updown zero", count, 0);
    chk("R7 updown flag", stat_flag, 1);
  endtask

  task automatic t_flag();
    do_reset();
    mode = 2'b01; term_cnt = 8'd2;
    run = 1; idle(1);
    ticks(2);
    idle(5);
    chk("R8 sticky", stat_flag, 1);
    ovf_mask = 0; #1;
    chk("R9 masked stat", stat_flag, 0);
    irq_en = 1; #1;
    chk("R10 masked irq", irq, 0);
    ovf_mask = 1; irq_en = 0; #1;
    chk("R9 unmasked stat", stat_flag, 1);
    chk("R10 no enable", irq, 0);
    irq_en = 1; #1;
    chk("R10 irq", irq, 1);
    idle(1);
    clear_flag();
    chk("R8 clear", stat_flag, 0);
    chk("R10 irq drops", irq, 0);
  endtask

  initial begin
    #(150000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_free();
    t_mod();
    t_down();
    t_updn();
    t_zero();
    t_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule